// File: doc/BRIEF.md
# Doorbell Interrupt Unit

This block lets software on any CPU ring doorbells on other CPUs, and lets inbound posted message writes ring doorbells as well. Every CPU owns a 32-bit pending (cause) register and a 32-bit enable (mask) register. It reaches them through its own small register port. A single trigger register is shared by all CPU ports and by the inbound message port. A value written there carries a target-CPU bitmap and a doorbell number. The unit then sets that doorbell's pending bit in every targeted CPU.

Each CPU has two interrupt lines. The low doorbell group (0 to 7) is used for CPU-to-CPU signalling and drives the first line. The high group (16 to 31) is used for message-signaled interrupts and drives the second line. A handler reads its pending register and then writes back the complement of the bits it has serviced. Any bit written as 1 is kept, so doorbells that arrived in the meantime survive the clear.

A message write for slot k carries the data word 0xF00 | (k + 16). Its target field is all ones, so it reaches every CPU. The CPU whose mask enables that doorbell takes it.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every pending register and every enable register reads 0, read data is 0, and all interrupt lines are low.
- R2: A write at offset 0x4, from any CPU port or from the message port, sets pending bit N in every CPU c where bit 8+c of the data is 1. N is data bits [4:0]. The bit reads back from the first read issued after the write cycle.
- R3: When data bits [11:8] are all ones (0xF), the doorbell is delivered to every CPU.
- R4: A message write with data 0xF00 | (k + 16) sets pending bit k+16 on every CPU.
- R5: A write to offset 0x8 of a CPU's port clears each pending bit of that CPU written as 0 and keeps each bit written as 1. Writing 0 clears them all.
- R6: Offset 0xC of each CPU port is that CPU's enable register. It is fully writable and readable, and only a write to that offset changes it.
- R7: The CPU-signal line of CPU c is high in the cycle after pending bits [7:0] and enable bits [7:0] share a set bit, and low otherwise.
- R8: The message line of CPU c is high in the cycle after pending bits [31:16] and enable bits [31:16] share a set bit, and low otherwise.
- R9: If a pending bit is set by a trigger and cleared by a pending-register write in the same cycle, the bit ends up set.
- R10: Read data appears one cycle after the address is presented. Offset 0x8 returns pending, offset 0xC returns enable, and any other offset returns 0. A write to any other offset changes no state.
- R11: Triggers from several sources in the same cycle are all delivered. Their bits are combined by OR.
- R12: Doorbells 8 to 15 set their pending bits but drive neither interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | NUM_CPUS | Per-CPU register write strobe |
| cpu_addr | input | NUM_CPUS*ADDR_W | Per-CPU register byte offset, CPU c in slice c |
| cpu_wdata | input | NUM_CPUS*32 | Per-CPU write data |
| msg_we | input | 1 | Inbound message write to the trigger register |
| msg_wdata | input | 32 | Inbound message data |
| cpu_rdata | output | NUM_CPUS*32 | Per-CPU registered read data |
| ipi_irq | output | NUM_CPUS | Per-CPU CPU-signal doorbell line (doorbells 0-7) |
| msg_irq | output | NUM_CPUS | Per-CPU message doorbell line (doorbells 16-31) |

## Verification
The assertions check four things on every cycle:
- A pending bit rises only because a trigger set it.
- A pending bit falls only on a pending-register write.
- A triggered bit always lands, even when a clear hits it in the same cycle.
- The enable register holds its value between writes, and an all-ones target field reaches every CPU.

Only the bench scenarios can show the rest. These are the exact bit positions of the field decode, the split between the two interrupt lines, and the silent middle group of doorbells. They also cover read latency and offset decoding, and the combining of several sources in one cycle.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int DB_W      = 32;
  localparam int DB_NUM_W  = 5;
  localparam int TGT_LSB   = 8;
  localparam int TGT_W     = 4;

  localparam int OFS_TRIGGER = 4;
  localparam int OFS_CAUSE   = 8;
  localparam int OFS_MASK    = 12;

  localparam logic [DB_W-1:0] IPI_RANGE = 32'h0000_00FF;
  localparam logic [DB_W-1:0] MSG_RANGE = 32'hFFFF_0000;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_CAUSE,
    RSEL_MASK
  } rsel_e;
endpackage

// File: rtl/doorbell_trigger_decode.sv
module doorbell_trigger_decode
  import doorbell_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       src_we,
  input  logic [NUM_SRC*DB_W-1:0]  src_wdata,
  output logic [NUM_CPUS*DB_W-1:0] set_flat
);
  logic [NUM_CPUS-1:0] tgt  [NUM_SRC];
  logic [DB_W-1:0]     bitv [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [TGT_W-1:0]    field;
    logic [DB_NUM_W-1:0] num;
    logic [NUM_CPUS-1:0] hit;

    assign field = src_wdata[s*DB_W+TGT_LSB +: TGT_W];
    assign num   = src_wdata[s*DB_W +: DB_NUM_W];
    // all-ones target field means broadcast
    assign tgt[s]  = !src_we[s]      ? '0 :
                     (field == '1)   ? '1 : field[NUM_CPUS-1:0];
    assign bitv[s] = DB_W'(1) << num;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_hit
      assign hit[c] = set_flat[c*DB_W + int'(num)];
    end

    // R3: a broadcast write reaches the combined set vector of every CPU
    assert_broadcast_R3: assert property (@(posedge clk) disable iff (rst)
      (src_we[s] && field == '1) |-> (hit == '1));
  end

  always_comb begin
    set_flat = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (tgt[s][c]) set_flat[c*DB_W +: DB_W] = set_flat[c*DB_W +: DB_W] | bitv[s];
      end
    end
  end
endmodule

// File: rtl/doorbell_cpu_bank.sv
module doorbell_cpu_bank
  import doorbell_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DB_W-1:0]   wdata,
  input  logic [DB_W-1:0]   set_vec,
  output logic [DB_W-1:0]   rdata,
  output logic              ipi_irq,
  output logic              msg_irq
);
  logic [DB_W-1:0] cause_q, mask_q, cause_nxt;
  logic            clr_we, mask_we;
  rsel_e           rsel;

  assign clr_we  = we && (addr == ADDR_W'(OFS_CAUSE));
  assign mask_we = we && (addr == ADDR_W'(OFS_MASK));

  always_comb begin
    rsel = RSEL_NONE;
    if (addr == ADDR_W'(OFS_CAUSE)) rsel = RSEL_CAUSE;
    else if (addr == ADDR_W'(OFS_MASK)) rsel = RSEL_MASK;
  end

  // clear first, then OR in new doorbells: trigger wins
  always_comb begin
    cause_nxt = clr_we ? (cause_q & wdata) : cause_q;
    cause_nxt = cause_nxt | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
      rdata   <= '0;
      ipi_irq <= 1'b0;
      msg_irq <= 1'b0;
    end else begin
      cause_q <= cause_nxt;
      if (mask_we) mask_q <= wdata;
      unique case (rsel)
        RSEL_CAUSE: rdata <= cause_q;
        RSEL_MASK:  rdata <= mask_q;
        default:    rdata <= '0;
      endcase
      ipi_irq <= |(cause_q & mask_q & IPI_RANGE);
      msg_irq <= |(cause_q & mask_q & MSG_RANGE);
    end
  end

  // R9: every bit set by a trigger is present next cycle
  assert_set_lands_R9: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  // R2: without a trigger no pending bit rises
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    (set_vec == '0) |=> ((cause_q & ~$past(cause_q)) == '0));

  // R5: pending bits fall only on a pending-register write
  assert_fall_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((~cause_q & $past(cause_q)) == '0));

  // R6: enable register holds between writes
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import doorbell_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CPUS-1:0]        cpu_we,
  input  logic [NUM_CPUS*ADDR_W-1:0] cpu_addr,
  input  logic [NUM_CPUS*DB_W-1:0]   cpu_wdata,
  input  logic                       msg_we,
  input  logic [DB_W-1:0]            msg_wdata,
  output logic [NUM_CPUS*DB_W-1:0]   cpu_rdata,
  output logic [NUM_CPUS-1:0]        ipi_irq,
  output logic [NUM_CPUS-1:0]        msg_irq
);
  localparam int NUM_SRC = NUM_CPUS + 1;

  logic [NUM_SRC-1:0]       src_we;
  logic [NUM_SRC*DB_W-1:0]  src_wdata;
  logic [NUM_CPUS*DB_W-1:0] set_flat;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_src_map
    assign src_we[c] = cpu_we[c] && (cpu_addr[c*ADDR_W +: ADDR_W] == ADDR_W'(OFS_TRIGGER));
    assign src_wdata[c*DB_W +: DB_W] = cpu_wdata[c*DB_W +: DB_W];
  end
  assign src_we[NUM_CPUS]                 = msg_we;
  assign src_wdata[NUM_CPUS*DB_W +: DB_W] = msg_wdata;

  doorbell_trigger_decode #(
    .NUM_CPUS(NUM_CPUS),
    .NUM_SRC (NUM_SRC)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .src_we   (src_we),
    .src_wdata(src_wdata),
    .set_flat (set_flat)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    doorbell_cpu_bank #(
      .ADDR_W(ADDR_W)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .we     (cpu_we[c]),
      .addr   (cpu_addr[c*ADDR_W +: ADDR_W]),
      .wdata  (cpu_wdata[c*DB_W +: DB_W]),
      .set_vec(set_flat[c*DB_W +: DB_W]),
      .rdata  (cpu_rdata[c*DB_W +: DB_W]),
      .ipi_irq(ipi_irq[c]),
      .msg_irq(msg_irq[c])
    );
  end
endmodule

// File: tb/test_doorbell_unit.sv
module test_doorbell_unit;
  localparam int NC = 4;
  localparam int AW = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic [NC-1:0]  cpu_we;
  logic [NC*AW-1:0] cpu_addr;
  logic [NC*32-1:0] cpu_wdata;
  logic           msg_we;
  logic [31:0]    msg_wdata;
  logic [NC*32-1:0] cpu_rdata;
  logic [NC-1:0]  ipi_irq, msg_irq;

  int n_checks = 0;
  int n_err    = 0;
  logic [31:0] m_cause [NC];
  logic [31:0] m_mask  [NC];

  always #4 clk = ~clk;

  doorbell_unit #(.NUM_CPUS(NC), .ADDR_W(AW)) i_doorbell_unit (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .msg_we(msg_we), .msg_wdata(msg_wdata),
    .cpu_rdata(cpu_rdata), .ipi_irq(ipi_irq), .msg_irq(msg_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model_trig(logic [31:0] d);
    logic [3:0] t;
    t = (d[11:8] == 4'hF) ? 4'hF : d[11:8];
    for (int c = 0; c < NC; c++) if (t[c]) m_cause[c] |= (32'd1 << d[4:0]);
  endfunction

  function automatic void model_write(int c, logic [3:0] a, logic [31:0] d);
    if (a == 4'h4) model_trig(d);
    else if (a == 4'h8) m_cause[c] &= d;
    else if (a == 4'hC) m_mask[c] = d;
  endfunction

  task automatic reg_write(int c, logic [3:0] a, logic [31:0] d);
    cpu_we[c] = 1'b1; cpu_addr[c*AW +: AW] = a; cpu_wdata[c*32 +: 32] = d;
    @(negedge clk);
    cpu_we[c] = 1'b0;
    model_write(c, a, d);
  endtask

  task automatic msg_write(logic [31:0] d);
    msg_we = 1'b1; msg_wdata = d;
    @(negedge clk);
    msg_we = 1'b0;
    model_trig(d);
  endtask

  task automatic reg_read(int c, logic [3:0] a, output logic [31:0] v);
    cpu_addr[c*AW +: AW] = a;
    @(negedge clk);
    v = cpu_rdata[c*32 +: 32];
  endtask

  task automatic check_state(string req);
    logic [31:0] v;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      check({req, " R7 ipi line"}, 32'(ipi_irq[c]), 32'(|(m_cause[c][7:0] & m_mask[c][7:0])));
      check({req, " R8 msg line"}, 32'(msg_irq[c]), 32'(|(m_cause[c][31:16] & m_mask[c][31:16])));
      reg_read(c, 4'h8, v);
      check({req, " R10 cause"}, v, m_cause[c]);
      reg_read(c, 4'hC, v);
      check({req, " R6 mask"}, v, m_mask[c]);
    end
  endtask

  task automatic t_reset;
    check("R1 rdata", cpu_rdata[31:0], 32'h0);
    check("R1 lines", 32'({ipi_irq, msg_irq}), 32'h0);
    check_state("R1");
  endtask

  task automatic t_ipi;
    reg_write(0, 4'h4, 32'h0000_0603);   // CPUs 1,2 doorbell 3
    check_state("R2");
    reg_write(1, 4'hC, 32'h0000_00FF);
    check_state("R7 enable");
  endtask

  task automatic t_clear;
    reg_write(1, 4'h8, ~32'h0000_0008);
    check_state("R5 complement");
    reg_write(0, 4'h4, 32'h0000_0402);
    reg_write(0, 4'h4, 32'h0000_0405);
    reg_write(2, 4'h8, 32'h0);
    check_state("R5 zero");
  endtask

  task automatic t_msi;
    msg_write(32'h0000_0F00 | (32'd5 + 32'd16));
    reg_write(3, 4'hC, 32'hFFFF_0000);
    check_state("R4 R8");
    check("R4 bit21", m_cause[0], 32'h0020_0000);
  endtask

  task automatic t_broadcast;
    reg_write(2, 4'h4, 32'h0000_0F00);
    check_state("R3");
  endtask

  task automatic t_collide;
    cpu_we[0] = 1'b1; cpu_addr[0 +: AW] = 4'h4; cpu_wdata[0 +: 32] = 32'h0000_0400;
    cpu_we[2] = 1'b1; cpu_addr[2*AW +: AW] = 4'h8; cpu_wdata[64 +: 32] = 32'h0;
    @(negedge clk);
    cpu_we = '0;
    m_cause[2] = 32'h0000_0001;
    check_state("R9");
  endtask

  task automatic t_multi;
    cpu_we[0] = 1'b1; cpu_addr[0 +: AW] = 4'h4; cpu_wdata[0 +: 32] = 32'h0000_0801;
    cpu_we[1] = 1'b1; cpu_addr[AW +: AW] = 4'h4; cpu_wdata[32 +: 32] = 32'h0000_0802;
    msg_we = 1'b1; msg_wdata = 32'h0000_0F10;
    @(negedge clk);
    cpu_we = '0; msg_we = 1'b0;
    model_trig(32'h0000_0801); model_trig(32'h0000_0802); model_trig(32'h0000_0F10);
    check_state("R11");
  endtask

  task automatic t_middle;
    reg_write(0, 4'h8, 32'h0);
    reg_write(0, 4'hC, 32'hFFFF_FFFF);
    reg_write(0, 4'h4, 32'h0000_010A);   // CPU 0 doorbell 10
    check_state("R12");
    check("R12 ipi0", 32'(ipi_irq[0]), 32'h0);
    check("R12 msg0", 32'(msg_irq[0]), 32'h0);
  endtask

  task automatic t_offsets;
    logic [31:0] v;
    reg_write(1, 4'h0, 32'hFFFF_FFFF);
    reg_write(1, 4'h4, 32'h0);           // CPU bitmap empty: no delivery
    reg_read(1, 4'h0, v);
    check("R10 offset0", v, 32'h0);
    reg_read(1, 4'h4, v);
    check("R10 offset4", v, 32'h0);
    check_state("R10 no effect");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_we = '0; cpu_addr = '0; cpu_wdata = '0; msg_we = 1'b0; msg_wdata = '0;
    for (int c = 0; c < NC; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ipi();
    t_clear();
    t_msi();
    t_broadcast();
    t_collide();
    t_multi();
    t_middle();
    t_offsets();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule